// File: doc/BRIEF.md
# Consecutive-Cycle Protection Fault Filter

This block sits between two noisy protection comparators of a switching power stage and the logic that turns the power switch off. It looks at each comparator once per switching cycle and declares a fault only when the comparator has tripped in a run of consecutive cycles. A single clean cycle breaks the run, so an isolated glitch never stops the converter.

The output-overvoltage comparator is looked at only inside a short strobe window. The window opens a programmable number of clocks after the turn-off edge and stays open for a programmable number of clocks. This is when the auxiliary winding reflects the output voltage. The second-level overcurrent comparator is looked at only while the switch is on, from the cycle-start pulse to the turn-off pulse. Each cycle's verdict is taken at the next cycle-start pulse. Confirmed faults are latched. Only a supply undervoltage indication (or reset) clears them. A combined shutdown request is raised in the same clock as either confirmed fault.

Top module: `cyc_fault_filter`

## Requirements
- R1: After synchronous reset, and while `rst` is high, `ovp_fault`, `ocp_fault` and `shutdown` are 0, and all streak counts and the warning state are cleared.
- R2: `ovp_cmp` counts only in the strobe window: the clocks whose turn-off counter value lies in STROBE_DLY to STROBE_DLY+STROBE_LEN-1. The counter is 0 in the first clock after the clock in which `toff_pulse` is high. A trip outside this window is ignored.
- R3: A cycle's verdict is taken at the next `cyc_start`. `ovp_fault` rises right after the `cyc_start` clock that closes the OVP_HITS-th (default 4) consecutive cycle with an overvoltage trip, and at no other time.
- R4: A cycle with no overvoltage trip in its window resets the overvoltage streak to zero.
- R5: `ocp_cmp` counts only during the on-time: after the clock in which `cyc_start` is high, up to and including the clock in which `toff_pulse` is high. A trip during the off-time is ignored.
- R6: The first overcurrent trip enters a warning state. If the next cycle is clean, the logic returns to idle and no fault results.
- R7: `ocp_fault` rises right after the `cyc_start` clock that closes the OCP_HITS-th (default 2) consecutive cycle with an overcurrent trip.
- R8: Any number of trips inside one cycle counts as a single tripped cycle.
- R9: `shutdown` always equals `ovp_fault` OR `ocp_fault`, and it rises in the same clock as the first confirmed fault.
- R10: Confirmed faults stay latched through any number of clean cycles. A clock with `uvlo` high clears both faults, `shutdown`, both streaks and the warning state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse at the start of each switching cycle (switch turn-on) |
| toff_pulse | input | 1 | One-clock pulse at the switch turn-off edge |
| ovp_cmp | input | 1 | Overvoltage comparator output, high when tripped |
| ocp_cmp | input | 1 | Second-level overcurrent comparator output, high when tripped |
| uvlo | input | 1 | High while the supply is below the undervoltage-off threshold |
| ovp_fault | output | 1 | Latched confirmed overvoltage fault |
| ocp_fault | output | 1 | Latched confirmed overcurrent fault |
| shutdown | output | 1 | Combined shutdown request |

## Verification
The two qualifiers can both confirm on the same cycle-start edge. In that case both flags and the single shutdown request must rise together in one clock. The bench provokes this by running two overvoltage-only cycles and then two cycles that trip both comparators. The overvoltage streak of four and the overcurrent streak of two then complete on the same verdict, and all three outputs are judged right after that edge. The windowing corners are judged the same way. These are trips just outside the strobe window or during the off-time, and repeated trips inside one cycle.

// File: rtl/cff_pkg.sv
package cff_pkg;

  // Streak qualifier states: idle, part-way through a streak, latched fault.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ARMED   = 2'd1,
    ST_LATCHED = 2'd2
  } streak_st_e;

  localparam int NUM_CH = 2;
  localparam int CH_OVP = 0;
  localparam int CH_OCP = 1;

endpackage

// File: rtl/cff_strobe.sv
module cff_strobe #(
  parameter int STROBE_DLY = 100,
  parameter int STROBE_LEN = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic cyc_start,
  input  logic toff_pulse,
  output logic window
);

  localparam int END_CNT = STROBE_DLY + STROBE_LEN;
  localparam int CW      = $clog2(END_CNT + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  // Counts clocks since turn-off; a new cycle start aborts a pending window.
  always_ff @(posedge clk) begin
    if (rst || clear || cyc_start) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (toff_pulse) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == CW'(END_CNT - 1)) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign window = run_q && (cnt_q >= CW'(STROBE_DLY));

endmodule

// File: rtl/cff_trip_catch.sv
module cff_trip_catch (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic eval,
  input  logic window,
  input  logic cmp,
  output logic seen
);

  logic seen_q;
  logic sample;

  assign sample = window & cmp;

  // Sticky per-cycle trip flag; the eval clock opens the next cycle.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      seen_q <= 1'b0;
    end else if (eval) begin
      seen_q <= sample;
    end else if (sample) begin
      seen_q <= 1'b1;
    end
  end

  assign seen = seen_q;

endmodule

// File: rtl/cff_streak.sv
module cff_streak
  import cff_pkg::*;
#(
  parameter int HITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic eval,
  input  logic seen,
  output logic hit,
  output logic fault,
  output logic warn
);

  localparam int CW = (HITS > 1) ? $clog2(HITS) : 1;

  streak_st_e    st_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (cnt_q == CW'(HITS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else if (eval) begin
      case (st_q)
        ST_IDLE, ST_ARMED: begin
          if (seen) begin
            if (last) begin
              st_q  <= ST_LATCHED;
              cnt_q <= '0;
            end else begin
              st_q  <= ST_ARMED;
              cnt_q <= cnt_q + 1'b1;
            end
          end else begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end
        end
        default: begin
          st_q  <= ST_LATCHED;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign hit   = !rst && !clear && eval && seen && (st_q != ST_LATCHED) && last;
  assign fault = (st_q == ST_LATCHED);
  assign warn  = (st_q == ST_ARMED);

endmodule

// File: rtl/cyc_fault_filter.sv
module cyc_fault_filter
  import cff_pkg::*;
#(
  parameter int STROBE_DLY = 100,
  parameter int STROBE_LEN = 25,
  parameter int OVP_HITS   = 4,
  parameter int OCP_HITS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic toff_pulse,
  input  logic ovp_cmp,
  input  logic ocp_cmp,
  input  logic uvlo,
  output logic ovp_fault,
  output logic ocp_fault,
  output logic shutdown
);

  logic              on_q;
  logic              strobe_win;
  logic [NUM_CH-1:0] ch_win;
  logic [NUM_CH-1:0] ch_cmp;
  logic [NUM_CH-1:0] ch_seen;
  logic [NUM_CH-1:0] ch_hit;
  logic [NUM_CH-1:0] ch_fault;
  logic [NUM_CH-1:0] ch_warn;
  logic              shut_q;

  // On-time tracker: switch on from cycle start until turn-off edge.
  always_ff @(posedge clk) begin
    if (rst || uvlo || toff_pulse) begin
      on_q <= 1'b0;
    end else if (cyc_start) begin
      on_q <= 1'b1;
    end
  end

  cff_strobe #(
    .STROBE_DLY(STROBE_DLY),
    .STROBE_LEN(STROBE_LEN)
  ) u_strobe (
    .clk       (clk),
    .rst       (rst),
    .clear     (uvlo),
    .cyc_start (cyc_start),
    .toff_pulse(toff_pulse),
    .window    (strobe_win)
  );

  assign ch_win[CH_OVP] = strobe_win;
  assign ch_win[CH_OCP] = on_q;
  assign ch_cmp[CH_OVP] = ovp_cmp;
  assign ch_cmp[CH_OCP] = ocp_cmp;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int CH_HITS = (g == CH_OVP) ? OVP_HITS : OCP_HITS;

    cff_trip_catch u_catch (
      .clk   (clk),
      .rst   (rst),
      .clear (uvlo),
      .eval  (cyc_start),
      .window(ch_win[g]),
      .cmp   (ch_cmp[g]),
      .seen  (ch_seen[g])
    );

    cff_streak #(
      .HITS(CH_HITS)
    ) u_streak (
      .clk  (clk),
      .rst  (rst),
      .clear(uvlo),
      .eval (cyc_start),
      .seen (ch_seen[g]),
      .hit  (ch_hit[g]),
      .fault(ch_fault[g]),
      .warn (ch_warn[g])
    );
  end

  // Combined request set in the same clock as the confirming verdict.
  always_ff @(posedge clk) begin
    if (rst || uvlo) begin
      shut_q <= 1'b0;
    end else if (|ch_hit) begin
      shut_q <= 1'b1;
    end
  end

  assign ovp_fault = ch_fault[CH_OVP];
  assign ocp_fault = ch_fault[CH_OCP];
  assign shutdown  = shut_q;

endmodule

// File: rtl/cff_chk.sv
module cff_chk (
  input logic clk,
  input logic rst,
  input logic cyc_start,
  input logic uvlo,
  input logic ovp_fault,
  input logic ocp_fault,
  input logic shutdown
);

  // R9
  shut_match_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown == (ovp_fault | ocp_fault));

  // R3
  ovp_rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovp_fault) |-> $past(cyc_start));

  // R7
  ocp_rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ocp_fault) |-> $past(cyc_start));

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((ovp_fault || ocp_fault) && !uvlo) |=> (ovp_fault || ocp_fault));

  // R10
  uvlo_clear_chk: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> (!ovp_fault && !ocp_fault && !shutdown));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!ovp_fault && !ocp_fault && !shutdown));

endmodule

bind cyc_fault_filter cff_chk u_cff_chk (
  .clk      (clk),
  .rst      (rst),
  .cyc_start(cyc_start),
  .uvlo     (uvlo),
  .ovp_fault(ovp_fault),
  .ocp_fault(ocp_fault),
  .shutdown (shutdown)
);

// File: tb/cyc_fault_filter_test.sv
module cyc_fault_filter_test;

  localparam int CLK_PERIOD = 10;
  localparam int T_DLY      = 6;
  localparam int T_LEN      = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0, toff_pulse = 1'b0;
  logic ovp_cmp = 1'b0, ocp_cmp = 1'b0, uvlo = 1'b0;
  logic ovp_fault, ocp_fault, shutdown;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cyc_fault_filter #(
    .STROBE_DLY(T_DLY),
    .STROBE_LEN(T_LEN),
    .OVP_HITS  (4),
    .OCP_HITS  (2)
  ) uut (
    .clk       (clk),
    .rst       (rst),
    .cyc_start (cyc_start),
    .toff_pulse(toff_pulse),
    .ovp_cmp   (ovp_cmp),
    .ocp_cmp   (ocp_cmp),
    .uvlo      (uvlo),
    .ovp_fault (ovp_fault),
    .ocp_fault (ocp_fault),
    .shutdown  (shutdown)
  );

  // Outputs compared as {ovp_fault, ocp_fault, shutdown}.
  task automatic check(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {ovp_fault, ocp_fault, shutdown};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic start();
    @(negedge clk); cyc_start = 1'b1;
    @(negedge clk); cyc_start = 1'b0;
  endtask

  // ocp_mode: 0 none, 1 one on-time clock, 2 four on-time clocks, 3 off-time only
  // ovp_mode: 0 none, 1 whole off-time, 2 only before the window
  task automatic body(input int ocp_mode, input int ovp_mode);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ocp_cmp = (ocp_mode == 1 && i == 2) || (ocp_mode == 2 && i >= 1 && i <= 4);
    end
    @(negedge clk); ocp_cmp = 1'b0; toff_pulse = 1'b1;
    for (int j = 1; j <= 16; j++) begin
      @(negedge clk);
      toff_pulse = 1'b0;
      ovp_cmp = (ovp_mode == 1) || (ovp_mode == 2 && j <= 3);
      ocp_cmp = (ocp_mode == 3);
    end
    @(negedge clk); ovp_cmp = 1'b0; ocp_cmp = 1'b0;
  endtask

  task automatic pulse_uvlo();
    @(negedge clk); uvlo = 1'b1;
    @(negedge clk); uvlo = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset", 3'b000);
  endtask

  task automatic t_ovp_streak();
    pulse_uvlo(); start();
    for (int k = 0; k < 3; k++) begin body(0, 1); start(); end
    check("R3 three trips", 3'b000);
    body(0, 1); start();
    check("R3 R9 fourth trip", 3'b101);
  endtask

  task automatic t_ovp_break();
    pulse_uvlo(); start();
    for (int k = 0; k < 3; k++) begin body(0, 1); start(); end
    body(0, 0); start();
    for (int k = 0; k < 3; k++) begin body(0, 1); start(); end
    check("R4 streak broken", 3'b000);
    body(0, 1); start();
    check("R4 new streak completes", 3'b101);
  endtask

  task automatic t_window();
    pulse_uvlo(); start();
    for (int k = 0; k < 5; k++) begin body(0, 2); start(); end
    check("R2 outside window", 3'b000);
  endtask

  task automatic t_multi();
    pulse_uvlo(); start();
    body(0, 1); start(); body(0, 1); start();
    check("R8 ovp samples once per cycle", 3'b000);
    pulse_uvlo(); start();
    body(2, 0); start(); body(0, 0); start();
    check("R8 ocp trips once per cycle", 3'b000);
  endtask

  task automatic t_ocp_warn();
    pulse_uvlo(); start();
    for (int k = 0; k < 4; k++) begin body(1, 0); start(); body(0, 0); start(); end
    check("R6 warning returns idle", 3'b000);
  endtask

  task automatic t_ocp_offtime();
    pulse_uvlo(); start();
    for (int k = 0; k < 3; k++) begin body(3, 0); start(); end
    check("R5 off-time ignored", 3'b000);
  endtask

  task automatic t_ocp_latch();
    pulse_uvlo(); start();
    body(1, 0); start();
    check("R7 one trip", 3'b000);
    body(1, 0); start();
    check("R7 R9 two trips", 3'b011);
    for (int k = 0; k < 3; k++) begin body(0, 0); start(); end
    check("R10 latched through clean", 3'b011);
    pulse_uvlo();
    check("R10 uvlo clears", 3'b000);
  endtask

  task automatic t_uvlo_streak();
    pulse_uvlo(); start();
    for (int k = 0; k < 3; k++) begin body(0, 1); start(); end
    body(0, 1); pulse_uvlo(); start();
    check("R10 uvlo clears streak", 3'b000);
    for (int k = 0; k < 3; k++) begin body(0, 1); start(); end
    check("R10 count restarted", 3'b000);
    body(0, 1); start();
    check("R10 streak after uvlo", 3'b101);
    for (int k = 0; k < 2; k++) begin body(0, 0); start(); end
    check("R10 ovp latched", 3'b101);
  endtask

  task automatic t_both();
    pulse_uvlo(); start();
    body(0, 1); start(); body(0, 1); start();
    body(1, 1); start();
    check("R9 pre-coincidence", 3'b000);
    body(1, 1); start();
    check("R9 both on same edge", 3'b111);
  endtask

  task automatic t_sync_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears latch", 3'b000);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ovp_streak();
    t_ovp_break();
    t_window();
    t_multi();
    t_ocp_warn();
    t_ocp_offtime();
    t_ocp_latch();
    t_uvlo_streak();
    t_both();
    t_sync_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL all: watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule